// File: doc/BRIEF.md
# Width-Selectable Processor Status Register

This block keeps the processor status word for an ALU that works at either 8-bit or 16-bit data width. Each cycle it can take an ALU outcome: a 16-bit result with its two operands, a full-precision divide quotient, or the two 32-bit terms of a multiply-accumulate step, together with an operation class. From these it derives the overflow flag V and the negative flag N. The sign position it looks at, bit 7 or bit 15, is chosen by the data-width flag m, which is held in this same register.

Software-style commands force status bits directly. A set mask and a clear mask act on every writable bit. Three single-purpose strobes set m, clear m and clear V. The register also holds the index-width flag x, a 3-bit interrupt priority field and four auxiliary flag bits that only the mask commands change. It drives the whole status word and the two width modes to the rest of the core.

Status word layout: bits 3:0 auxiliary flags, bit 4 x, bit 5 m, bit 6 V, bit 7 N, bits 10:8 interrupt priority, bits 15:11 reserved.

Top module: `pstat_unit`

## Requirements
- R1: While rst_n is low, and after it is released with no command or ALU update, status reads 16'h0000 and idx_8bit and dat_8bit read 0.
- R2: Bits 15:11 of status always read 0, even after set_mask = 16'hFFFF. The writable mask is 16'h07FF.
- R3: idx_8bit equals status bit 4 (x; 1 = 8-bit index registers) and dat_8bit equals status bit 5 (m; 1 = 8-bit data). Both are changed through the mask commands.
- R4: With alu_valid high and alu_op = 1 (add), V becomes 1 when op_a and op_b have equal signs and result has the other sign, and 0 otherwise. The sign is bit 15 when m = 0 and bit 7 when m = 1.
- R5: With alu_op = 2 (subtract), V follows the same rule as R4 with the sign of op_b inverted.
- R6: For alu_op 1, 2, 3 (transfer), 4 (divide) and 5 (multiply-accumulate), N becomes result bit 15 when m = 0 and result bit 7 when m = 1.
- R7: With alu_op = 4, V becomes 1 when div_quot does not fit the selected width. When div_signed = 0 the quotient is treated as unsigned; when div_signed = 1 it is treated as two's complement.
- R8: With alu_op = 5, V becomes 1 when the signed 32-bit sum mac_acc + mac_term falls outside -2147483648 to +2147483647, and 0 otherwise.
- R9: A transfer leaves V unchanged. alu_valid low, or alu_op 0, 6 or 7, leaves V and N unchanged.
- R10: A 1 in set_mask sets that writable bit and a 1 in clr_mask clears it, from the next clock edge. When both masks name the same bit, the bit is set.
- R11: m_set sets bit 5, m_clr clears bit 5 (m_set wins if both are high), and v_clr clears bit 6.
- R12: When a command and an ALU update name the same bit in one cycle, the command's value is stored. ALU updates to bits the command does not name still take effect.
- R13: An ALU update uses the m value held before the clock edge, even when a command changes m in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| alu_valid | input | 1 | ALU outcome present this cycle |
| alu_op | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 transfer, 4 divide, 5 multiply-accumulate |
| op_a | input | 16 | First ALU operand |
| op_b | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| div_quot | input | 32 | Full-precision divide quotient |
| div_signed | input | 1 | Divide is signed |
| mac_acc | input | 32 | Multiply-accumulate running sum |
| mac_term | input | 32 | Multiply-accumulate product term |
| set_mask | input | 16 | Bits to force to 1 |
| clr_mask | input | 16 | Bits to force to 0 |
| m_set | input | 1 | Set the data-width flag |
| m_clr | input | 1 | Clear the data-width flag |
| v_clr | input | 1 | Clear the overflow flag |
| status | output | 16 | Status word |
| idx_8bit | output | 1 | Index registers are 8 bits wide |
| dat_8bit | output | 1 | Data is 8 bits wide |

## Verification
The bench drives sign-boundary sums and differences at both widths, so it catches:
- a design that reads the wrong sign bit for the width, which would flag overflow on 16'h7F00 + 16'h0100 at 8-bit width;
- a subtraction that keeps op_b's sign, which would miss 16'h8000 - 1.

Divide quotients sit exactly at the signed and unsigned limits, -32768 and 65535, where an off-by-one range check misreports V. Collisions are also exercised:
- set and clear masks naming one bit;
- a clear of V arriving with an overflowing add;
- an m change arriving with an 8-bit add.

Each of these exposes a wrong priority or an ALU update computed at the new width instead of the held one.

// File: rtl/pstat_pkg.sv
package pstat_pkg;
  localparam int unsigned SW = 16;
  localparam int unsigned BIT_X = 4;
  localparam int unsigned BIT_M = 5;
  localparam int unsigned BIT_V = 6;
  localparam int unsigned BIT_N = 7;
  localparam int unsigned IPL_LO = 8;
  localparam int unsigned IPLW = 3;
  localparam int unsigned RSV_LO = IPL_LO + IPLW;
  localparam logic [SW-1:0] WR_MASK = SW'((1 << RSV_LO) - 1);

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_XFER = 3'd3,
    OP_DIV  = 3'd4,
    OP_MAC  = 3'd5
  } alu_op_e;
endpackage

// File: rtl/pstat_flag_eval.sv
module pstat_flag_eval
  import pstat_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8,
  parameter int unsigned AW = 32
) (
  input  logic          alu_valid,
  input  logic [2:0]    alu_op,
  input  logic          m_byte,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] result,
  input  logic [AW-1:0] div_quot,
  input  logic          div_signed,
  input  logic [AW-1:0] mac_acc,
  input  logic [AW-1:0] mac_term,
  output logic          upd_v,
  output logic          v_new,
  output logic          upd_n,
  output logic          n_new
);
  localparam int unsigned WHI = DW - 1;
  localparam int unsigned NHI = NW - 1;

  logic sa, sb, sr;
  logic add_ov, sub_ov, div_ov, mac_ov;
  logic div_u_fit, div_s_fit;
  logic [AW-1:0] mac_sum;
  alu_op_e op;

  always_comb begin
    op = alu_op_e'(alu_op);
    sa = m_byte ? op_a[NHI]   : op_a[WHI];
    sb = m_byte ? op_b[NHI]   : op_b[WHI];
    sr = m_byte ? result[NHI] : result[WHI];
    add_ov = (sa == sb) && (sr != sa);
    sub_ov = (sa != sb) && (sr != sa);
  end

  always_comb begin
    if (m_byte) begin
      div_u_fit = (div_quot[AW-1:NW] == '0);
      div_s_fit = (div_quot[AW-1:NHI] == '0) || (&div_quot[AW-1:NHI]);
    end else begin
      div_u_fit = (div_quot[AW-1:DW] == '0);
      div_s_fit = (div_quot[AW-1:WHI] == '0) || (&div_quot[AW-1:WHI]);
    end
    div_ov = div_signed ? !div_s_fit : !div_u_fit;
  end

  always_comb begin
    mac_sum = mac_acc + mac_term;
    mac_ov  = (mac_acc[AW-1] == mac_term[AW-1]) && (mac_sum[AW-1] != mac_acc[AW-1]);
  end

  always_comb begin
    upd_v = 1'b0;
    v_new = 1'b0;
    upd_n = 1'b0;
    n_new = sr;
    if (alu_valid) begin
      unique case (op)
        OP_ADD:  begin upd_v = 1'b1; v_new = add_ov; upd_n = 1'b1; end
        OP_SUB:  begin upd_v = 1'b1; v_new = sub_ov; upd_n = 1'b1; end
        OP_XFER: begin upd_n = 1'b1; end
        OP_DIV:  begin upd_v = 1'b1; v_new = div_ov; upd_n = 1'b1; end
        OP_MAC:  begin upd_v = 1'b1; v_new = mac_ov; upd_n = 1'b1; end
        default: begin end
      endcase
    end
  end
endmodule

// File: rtl/pstat_cmd_merge.sv
module pstat_cmd_merge
  import pstat_pkg::*;
(
  input  logic [SW-1:0] set_mask,
  input  logic [SW-1:0] clr_mask,
  input  logic          m_set,
  input  logic          m_clr,
  input  logic          v_clr,
  output logic [SW-1:0] frc_set,
  output logic [SW-1:0] frc_clr,
  output logic          cmd_any
);
  logic [SW-1:0] set_raw, clr_raw;

  always_comb begin
    set_raw = set_mask;
    clr_raw = clr_mask;
    set_raw[BIT_M] = set_raw[BIT_M] | m_set;
    clr_raw[BIT_M] = clr_raw[BIT_M] | m_clr;
    clr_raw[BIT_V] = clr_raw[BIT_V] | v_clr;
    frc_set = set_raw & WR_MASK;
    frc_clr = clr_raw & WR_MASK & ~frc_set;
    cmd_any = |(frc_set | frc_clr);
  end
endmodule

// File: rtl/pstat_unit.sv
module pstat_unit
  import pstat_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NW = 8,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_valid,
  input  logic [2:0]    alu_op,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] result,
  input  logic [AW-1:0] div_quot,
  input  logic          div_signed,
  input  logic [AW-1:0] mac_acc,
  input  logic [AW-1:0] mac_term,
  input  logic [SW-1:0] set_mask,
  input  logic [SW-1:0] clr_mask,
  input  logic          m_set,
  input  logic          m_clr,
  input  logic          v_clr,
  output logic [SW-1:0] status,
  output logic          idx_8bit,
  output logic          dat_8bit
);
  logic [SW-1:0] st_q, st_d, frc_set, frc_clr;
  logic          st_en, cmd_any;
  logic          upd_v, v_new, upd_n, n_new;

  pstat_flag_eval #(.DW(DW), .NW(NW), .AW(AW)) u_eval (
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .m_byte    (st_q[BIT_M]),
    .op_a      (op_a),
    .op_b      (op_b),
    .result    (result),
    .div_quot  (div_quot),
    .div_signed(div_signed),
    .mac_acc   (mac_acc),
    .mac_term  (mac_term),
    .upd_v     (upd_v),
    .v_new     (v_new),
    .upd_n     (upd_n),
    .n_new     (n_new)
  );

  pstat_cmd_merge u_cmd (
    .set_mask(set_mask),
    .clr_mask(clr_mask),
    .m_set   (m_set),
    .m_clr   (m_clr),
    .v_clr   (v_clr),
    .frc_set (frc_set),
    .frc_clr (frc_clr),
    .cmd_any (cmd_any)
  );

  always_comb begin
    st_d = st_q;
    if (upd_n) st_d[BIT_N] = n_new;
    if (upd_v) st_d[BIT_V] = v_new;
    st_d  = ((st_d & ~frc_clr) | frc_set) & WR_MASK;
    st_en = upd_n | upd_v | cmd_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status   = st_q;
  assign idx_8bit = st_q[BIT_X];
  assign dat_8bit = st_q[BIT_M];

  // R2: reserved field never holds a 1
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[SW-1:RSV_LO] == '0);

  // R10: a set-mask bit is present after the edge
  assert_set_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask[IPL_LO] |=> st_q[IPL_LO]);

  // R10: a clear-mask bit without a matching set is gone after the edge
  assert_clr_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask[BIT_X] && !set_mask[BIT_X]) |=> !st_q[BIT_X]);

  // R9: transfer with no command on V keeps V
  assert_xfer_keeps_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op == 3'd3 && !set_mask[BIT_V] && !clr_mask[BIT_V] && !v_clr)
      |=> st_q[BIT_V] == $past(st_q[BIT_V]));

  // R11: dedicated V clear always wins over an ALU overflow
  assert_vclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (v_clr && !set_mask[BIT_V]) |=> !st_q[BIT_V]);

  // R6: at 16-bit width an uncommanded add leaves N equal to result bit 15
  assert_n_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op == 3'd1 && !st_q[BIT_M] && set_mask[BIT_N] == 1'b0
     && clr_mask[BIT_N] == 1'b0) |=> st_q[BIT_N] == $past(result[DW-1]));
endmodule

// File: tb/test_pstat_unit.sv
module test_pstat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_valid;
  logic [2:0]  alu_op;
  logic [15:0] op_a, op_b, result;
  logic [31:0] div_quot, mac_acc, mac_term;
  logic        div_signed;
  logic [15:0] set_mask, clr_mask;
  logic        m_set, m_clr, v_clr;
  logic [15:0] status;
  logic        idx_8bit, dat_8bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pstat_unit i_pstat_unit (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
    .op_a(op_a), .op_b(op_b), .result(result), .div_quot(div_quot),
    .div_signed(div_signed), .mac_acc(mac_acc), .mac_term(mac_term),
    .set_mask(set_mask), .clr_mask(clr_mask), .m_set(m_set), .m_clr(m_clr),
    .v_clr(v_clr), .status(status), .idx_8bit(idx_8bit), .dat_8bit(dat_8bit)
  );

  // {m, op[2:0], a, b, r, chk_v, exp_v, exp_n}
  localparam logic [54:0] VEC [0:10] = '{
    {1'b0, 3'd1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b1, 1'b1}, // R4
    {1'b0, 3'd1, 16'h0001, 16'h0001, 16'h0002, 1'b1, 1'b0, 1'b0}, // R4
    {1'b0, 3'd1, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1, 1'b0}, // R4
    {1'b0, 3'd2, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1, 1'b0}, // R5
    {1'b0, 3'd2, 16'h0005, 16'h0003, 16'h0002, 1'b1, 1'b0, 1'b0}, // R5
    {1'b1, 3'd1, 16'h007F, 16'h0001, 16'h0080, 1'b1, 1'b1, 1'b1}, // R4 narrow
    {1'b1, 3'd1, 16'h7F00, 16'h0100, 16'h8000, 1'b1, 1'b0, 1'b0}, // R4 narrow
    {1'b1, 3'd2, 16'h0080, 16'h0001, 16'h007F, 1'b1, 1'b1, 1'b0}, // R5 narrow
    {1'b1, 3'd2, 16'h00FF, 16'h0001, 16'h00FE, 1'b1, 1'b0, 1'b1}, // R5 narrow
    {1'b0, 3'd3, 16'h0000, 16'h0000, 16'h8000, 1'b0, 1'b0, 1'b1}, // R6
    {1'b1, 3'd3, 16'h0000, 16'h0000, 16'h0040, 1'b0, 1'b0, 1'b0}  // R6
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    alu_valid = 0; alu_op = 0; op_a = 0; op_b = 0; result = 0;
    div_quot = 0; div_signed = 0; mac_acc = 0; mac_term = 0;
    set_mask = 0; clr_mask = 0; m_set = 0; m_clr = 0; v_clr = 0;
  endtask

  // drive at negedge, one posedge, return at next negedge with inputs idle
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic alu(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                     input logic [15:0] r);
    alu_valid = 1; alu_op = op; op_a = a; op_b = b; result = r;
    step();
  endtask

  task automatic clear_all();
    clr_mask = 16'hFFFF;
    step();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", status, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    check("R1 status after release", status, 16'h0000);
    check("R1 modes", {14'd0, idx_8bit, dat_8bit}, 16'h0000);

    // vector table
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][54]) m_set = 1; else m_clr = 1;
      clr_mask = 16'h00C0;
      step();
      alu(VEC[i][53:51], VEC[i][50:35], VEC[i][34:19], VEC[i][18:3]);
      check($sformatf("R6 N vec %0d", i), {15'd0, status[7]}, {15'd0, VEC[i][0]});
      if (VEC[i][2])
        check($sformatf("R4/R5 V vec %0d", i), {15'd0, status[6]}, {15'd0, VEC[i][1]});
      check($sformatf("R3 dat_8bit vec %0d", i), {15'd0, dat_8bit}, {15'd0, VEC[i][54]});
    end

    // R2, R3: full set, reserved stays zero
    clear_all();
    set_mask = 16'hFFFF; step();
    check("R2 reserved zero", status, 16'h07FF);
    check("R3 modes", {14'd0, idx_8bit, dat_8bit}, 16'h0003);
    clear_all();
    check("R10 clear all", status, 16'h0000);

    // R10 both masks on one bit
    set_mask = 16'h0100; clr_mask = 16'h0100; step();
    check("R10 set wins", status, 16'h0100);

    // R9 transfer keeps V; idle op keeps flags
    clear_all();
    set_mask = 16'h0040; step();
    alu(3'd3, 16'h0, 16'h0, 16'h0000);
    check("R9 xfer keeps V", status, 16'h0040);
    alu(3'd0, 16'h7FFF, 16'h0001, 16'h8000);
    check("R9 op none", status, 16'h0040);
    alu_valid = 0; alu_op = 3'd1; op_a = 16'h7FFF; op_b = 16'h0001; result = 16'h8000; step();
    check("R9 valid low", status, 16'h0040);

    // R12 command beats ALU on V, N still from ALU
    clear_all();
    clr_mask = 16'h0040; alu(3'd1, 16'h7FFF, 16'h0001, 16'h8000);
    check("R12 command wins", status, 16'h0080);

    // R11 dedicated strobes
    clear_all();
    m_set = 1; step();
    check("R11 m_set", status, 16'h0020);
    m_clr = 1; step();
    check("R11 m_clr", status, 16'h0000);
    m_set = 1; m_clr = 1; step();
    check("R11 both", status, 16'h0020);
    set_mask = 16'h0040; step();
    v_clr = 1; step();
    check("R11 v_clr", status, 16'h0020);

    // R7 divide
    clear_all();
    div_quot = 32'h0001_0000; alu(3'd4, 0, 0, 16'h0000);
    check("R7 unsigned wide over", status, 16'h0040);
    div_quot = 32'h0000_FFFF; alu(3'd4, 0, 0, 16'hFFFF);
    check("R7 unsigned wide fit", status, 16'h0080);
    div_quot = 32'hFFFF_8000; div_signed = 1; alu(3'd4, 0, 0, 16'h8000);
    check("R7 signed wide fit", status, 16'h0080);
    div_quot = 32'h0000_8000; div_signed = 1; alu(3'd4, 0, 0, 16'h8000);
    check("R7 signed wide over", status, 16'h00C0);
    clear_all();
    m_set = 1; step();
    div_quot = 32'h0000_0100; alu(3'd4, 0, 0, 16'h0000);
    check("R7 unsigned narrow over", status, 16'h0060);
    div_quot = 32'hFFFF_FF80; div_signed = 1; alu(3'd4, 0, 0, 16'h0080);
    check("R7 signed narrow fit", status, 16'h00A0);

    // R8 multiply-accumulate
    clear_all();
    mac_acc = 32'h7FFF_FFFF; mac_term = 32'h1; alu(3'd5, 0, 0, 16'h0000);
    check("R8 positive over", status, 16'h0040);
    mac_acc = 32'hFFFF_FFFF; mac_term = 32'h1; alu(3'd5, 0, 0, 16'h0000);
    check("R8 no over", status, 16'h0000);
    mac_acc = 32'h8000_0000; mac_term = 32'hFFFF_FFFF; alu(3'd5, 0, 0, 16'h0000);
    check("R8 negative over", status, 16'h0040);

    // R13 ALU uses held m while m is cleared in the same cycle
    clear_all();
    m_set = 1; step();
    m_clr = 1; alu(3'd1, 16'h007F, 16'h0001, 16'h0080);
    check("R13 held width", status, 16'h00C0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule